// File: doc/BRIEF.md
# Receive Beamforming Weight Engine (Dual Power Iteration)

This block turns a frame of per-subcarrier channel estimates into four complex receive weights that maximise the combined signal-to-noise ratio of an analog-combining multi-antenna link. The estimates arrive as a stream of complex samples, one per cycle when `in_valid` is high. The stream covers every equivalent single-antenna channel (NT transmit × NR receive pairs) at every active subcarrier. The samples are stored, and the block then builds a 16×16 Hermitian correlation matrix by summing outer products over the subcarriers. Only the upper triangle is ever summed; lower entries are read back as conjugates.

A fixed-count power iteration then finds the dominant eigenvector of that matrix. The 16-element result is reshaped by columns into a 4×4 matrix Z, the product Z·Zᴴ is formed, and a second fixed-count power iteration on that 4×4 product yields the receive weight vector. The vector passed between iterations and stages is kept to W-bit signed parts by a block-exponent right shift. When the weights are ready they appear on the outputs together with a one-cycle `done` pulse, and the block accepts the next frame.

Top module: `pim_rx_weights`

## Requirements
- R1: Accepted samples (cycles with `in_valid` high while idle) are ordered channel-major. Sample number i·NSC+k is subcarrier k of channel i, and a frame is complete after NCH·NSC accepted samples (NCH = NT·NR).
- R2: The correlation matrix is exact integer arithmetic, Y[i][j] = Σk x(i,k)·conj(x(j,k)), with no rounding or saturation.
- R3: The first power iteration starts from the all-(1+0j) vector and applies v ← norm(Y·v) exactly ITER times, with exact products and sums.
- R4: Normalisation: let n be the smallest two's-complement width that holds every real and imaginary part of the vector (n = 1 for an all-zero vector). Each part is shifted right arithmetically (floor) by max(0, n−W) and kept as W-bit signed.
- R5: The 16-element vector z maps to Z by columns, Z[r][c] = z[c·NR + r]. So channel i = tx·NR + rx, and row r of Z is receive antenna r.
- R6: M = Z·Zᴴ is formed exactly. A second power iteration from the all-(1+0j) 4-vector applies v ← norm(M·v) ITER times, and its result is the weight vector. Weight r sits in bits [r·W +: W] of `wgt_re`/`wgt_im`.
- R7: `done` is high for exactly one cycle, in the cycle the new weights first appear, and the weights hold their value in every other cycle.
- R8: `in_valid` is ignored from frame completion until `done`. Samples offered then neither change the weights nor count toward the next frame.
- R9: Synchronous reset clears the weights to zero, deasserts `done` and discards any partly received frame.
- R10: An all-zero frame gives all-zero weights.
- R11: Full-scale inputs (parts of −2^(W−1)) produce no internal overflow: the weights still follow R2–R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_re | input | W | Sample real part, signed |
| in_im | input | W | Sample imaginary part, signed |
| wgt_re | output | NR·W | Receive weight real parts, weight r at bits [r·W +: W] |
| wgt_im | output | NR·W | Receive weight imaginary parts, same packing |
| done | output | 1 | One-cycle pulse when new weights are presented |

## Verification
Pseudo-random frames with two seeds exercise both power iterations on full-rank matrices, where any error in a conjugate, a sign or a shift amount changes the result. A rank-one frame built as a channel vector times a ±1 subcarrier sequence has a known dominant direction and separates correct Hermitian mirroring from a plain transpose. A frame with only one nonzero channel must steer all energy to one receive antenna, so it exposes a wrong channel order or row/column swap in the reshape. All-zero and full-scale frames probe the two ends of the normalisation: zero shift, and the widest accumulator values.

// File: rtl/pim_pkg.sv
package pim_pkg;

  // Control phases of the weight engine
  typedef enum logic [2:0] {
    S_LOAD,   // collecting samples
    S_GRAM,   // summing upper triangle of the correlation matrix
    S_PM,     // one matrix-vector product, one complex MAC per cycle
    S_NORM,   // block-exponent shift of the product
    S_ZZH     // reshape and Z*Z^H formation
  } pim_state_t;

endpackage

// File: rtl/pim_sample_ram.sv
module pim_sample_ram #(
  parameter int DEPTH = 832,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem [DEPTH];

  // one write port, two registered read ports
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/pim_norm.sv
module pim_norm #(
  parameter int N  = 16,
  parameter int PW = 36,
  parameter int W  = 8
) (
  input  logic signed [PW-1:0] in_re  [N],
  input  logic signed [PW-1:0] in_im  [N],
  output logic signed [W-1:0]  out_re [N],
  output logic signed [W-1:0]  out_im [N]
);

  localparam int SHW = $clog2(PW + 1);

  logic [PW-1:0]  mag_or;
  logic [SHW-1:0] need;
  logic [SHW-1:0] shift;

  // the OR of all sign-folded parts has the bit length of the widest part
  always_comb begin
    mag_or = '0;
    for (int i = 0; i < N; i++) begin
      mag_or |= in_re[i][PW-1] ? ~in_re[i] : in_re[i];
      mag_or |= in_im[i][PW-1] ? ~in_im[i] : in_im[i];
    end
    need = SHW'(1);
    for (int b = 0; b < PW; b++)
      if (mag_or[b]) need = SHW'(b + 2);
    shift = (need > SHW'(W)) ? need - SHW'(W) : '0;
    for (int i = 0; i < N; i++) begin
      out_re[i] = W'(in_re[i] >>> shift);
      out_im[i] = W'(in_im[i] >>> shift);
    end
  end

endmodule

// File: rtl/pim_rx_weights.sv
module pim_rx_weights
  import pim_pkg::*;
#(
  parameter int NT   = 4,
  parameter int NR   = 4,
  parameter int NSC  = 52,
  parameter int W    = 8,
  parameter int ITER = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W-1:0]    in_re,
  input  logic [W-1:0]    in_im,
  output logic [NR*W-1:0] wgt_re,
  output logic [NR*W-1:0] wgt_im,
  output logic            done
);

  localparam int NCH   = NT * NR;
  localparam int DEPTH = NCH * NSC;
  localparam int SCW   = $clog2(DEPTH);
  localparam int CW    = $clog2(NCH);
  localparam int KW    = $clog2(NSC);
  localparam int RW    = $clog2(NR);
  localparam int IW    = $clog2(ITER + 1);
  localparam int AWID  = 2*W + 1 + $clog2(NSC);   // correlation entry width
  localparam int PW    = AWID + W + 1 + CW;       // matrix-vector sum width

  function automatic logic signed [AWID-1:0] ext(input logic signed [W-1:0] x);
    return AWID'(x);
  endfunction

  pim_state_t           st;
  logic [SCW-1:0]       smp_cnt;
  logic [CW-1:0]        gi, gj, ri, rj;
  logic [KW-1:0]        gk;
  logic                 issuing, rd_vld, rd_last;
  logic [2*W-1:0]       rd_a, rd_b;
  logic [SCW-1:0]       addr_a, addr_b;
  logic signed [AWID-1:0] acc_re, acc_im, g_re, g_im;
  logic signed [AWID-1:0] y_re [NCH][NCH];
  logic signed [AWID-1:0] y_im [NCH][NCH];
  logic signed [AWID-1:0] m_re [NR][NR], m_im [NR][NR];
  logic signed [AWID-1:0] m_nre [NR][NR], m_nim [NR][NR];
  logic signed [W-1:0]  v_re [NCH], v_im [NCH];
  logic signed [W-1:0]  n_re [NCH], n_im [NCH];
  logic signed [PW-1:0] u_re [NCH], u_im [NCH];
  logic signed [PW-1:0] e_re, e_im, p_re, p_im;
  logic signed [AWID-1:0] a_re, a_im;
  logic [CW-1:0]        ei, ej, dim_last;
  logic [IW-1:0]        iter;
  logic                 stage2;

  // ---------------- sample store ----------------
  assign addr_a = SCW'(gi) * SCW'(NSC) + SCW'(gk);
  assign addr_b = SCW'(gj) * SCW'(NSC) + SCW'(gk);

  pim_sample_ram #(.DEPTH(DEPTH), .DW(2*W)) u_ram (
    .clk     (clk),
    .we      (st == S_LOAD && in_valid),
    .waddr   (smp_cnt),
    .wdata   ({in_re, in_im}),
    .raddr_a (addr_a),
    .raddr_b (addr_b),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  // x_i * conj(x_j) for the pair being read
  always_comb begin
    logic signed [AWID-1:0] ar, ai, br, bi;
    ar = ext(signed'(rd_a[2*W-1:W]));  ai = ext(signed'(rd_a[W-1:0]));
    br = ext(signed'(rd_b[2*W-1:W]));  bi = ext(signed'(rd_b[W-1:0]));
    g_re = ar*br + ai*bi;
    g_im = ai*br - ar*bi;
  end

  // ---------------- matrix element select and MAC ----------------
  assign dim_last = stage2 ? CW'(NR-1) : CW'(NCH-1);

  always_comb begin
    logic signed [PW-1:0] xr, xi, vr, vi;
    if (stage2) begin
      a_re = m_re[ei[RW-1:0]][ej[RW-1:0]];
      a_im = m_im[ei[RW-1:0]][ej[RW-1:0]];
    end else if (ei <= ej) begin
      a_re = y_re[ei][ej];
      a_im = y_im[ei][ej];
    end else begin                       // lower triangle = conjugate mirror
      a_re = y_re[ej][ei];
      a_im = -y_im[ej][ei];
    end
    xr = PW'(a_re);       xi = PW'(a_im);
    vr = PW'(v_re[ej]);   vi = PW'(v_im[ej]);
    p_re = xr*vr - xi*vi;
    p_im = xr*vi + xi*vr;
  end

  // ---------------- reshape by columns and Z*Z^H ----------------
  always_comb begin
    for (int a = 0; a < NR; a++) begin
      for (int b = 0; b < NR; b++) begin
        m_nre[a][b] = '0;
        m_nim[a][b] = '0;
        for (int c = 0; c < NT; c++) begin
          m_nre[a][b] += ext(v_re[c*NR+a])*ext(v_re[c*NR+b]) + ext(v_im[c*NR+a])*ext(v_im[c*NR+b]);
          m_nim[a][b] += ext(v_im[c*NR+a])*ext(v_re[c*NR+b]) - ext(v_re[c*NR+a])*ext(v_im[c*NR+b]);
        end
      end
    end
  end

  pim_norm #(.N(NCH), .PW(PW), .W(W)) u_norm (
    .in_re (u_re), .in_im (u_im), .out_re (n_re), .out_im (n_im)
  );

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st      <= S_LOAD;
      smp_cnt <= '0;
      wgt_re  <= '0;
      wgt_im  <= '0;
      issuing <= 1'b0;
      rd_vld  <= 1'b0;
      rd_last <= 1'b0;
      acc_re  <= '0;
      acc_im  <= '0;
      stage2  <= 1'b0;
      iter    <= '0;
    end else begin
      case (st)
        S_LOAD: if (in_valid) begin
          if (smp_cnt == SCW'(DEPTH-1)) begin
            smp_cnt <= '0;
            gi <= '0; gj <= '0; gk <= '0;
            issuing <= 1'b1;
            st <= S_GRAM;
          end else begin
            smp_cnt <= smp_cnt + 1'b1;
          end
        end
        S_GRAM: begin
          rd_vld  <= issuing;
          rd_last <= (gk == KW'(NSC-1));
          ri <= gi;
          rj <= gj;
          if (issuing) begin
            if (gk == KW'(NSC-1)) begin
              gk <= '0;
              if (gj == CW'(NCH-1)) begin
                if (gi == CW'(NCH-1)) issuing <= 1'b0;
                else begin gi <= gi + 1'b1; gj <= gi + 1'b1; end
              end else gj <= gj + 1'b1;
            end else gk <= gk + 1'b1;
          end
          if (rd_vld) begin
            if (rd_last) begin
              y_re[ri][rj] <= acc_re + g_re;
              y_im[ri][rj] <= acc_im + g_im;
              acc_re <= '0;
              acc_im <= '0;
            end else begin
              acc_re <= acc_re + g_re;
              acc_im <= acc_im + g_im;
            end
          end
          if (!issuing && !rd_vld) begin
            for (int i = 0; i < NCH; i++) begin v_re[i] <= W'(1); v_im[i] <= '0; end
            stage2 <= 1'b0;
            iter <= '0;
            ei <= '0; ej <= '0; e_re <= '0; e_im <= '0;
            st <= S_PM;
          end
        end
        S_PM: begin
          if (ej == dim_last) begin
            u_re[ei] <= e_re + p_re;
            u_im[ei] <= e_im + p_im;
            e_re <= '0; e_im <= '0; ej <= '0;
            if (ei == dim_last) begin ei <= '0; st <= S_NORM; end
            else ei <= ei + 1'b1;
          end else begin
            e_re <= e_re + p_re;
            e_im <= e_im + p_im;
            ej <= ej + 1'b1;
          end
        end
        S_NORM: begin
          for (int i = 0; i < NCH; i++) begin v_re[i] <= n_re[i]; v_im[i] <= n_im[i]; end
          if (iter == IW'(ITER-1)) begin
            iter <= '0;
            if (!stage2) st <= S_ZZH;
            else begin
              for (int r = 0; r < NR; r++) begin
                wgt_re[r*W +: W] <= n_re[r];
                wgt_im[r*W +: W] <= n_im[r];
              end
              done <= 1'b1;
              st <= S_LOAD;
            end
          end else begin
            iter <= iter + 1'b1;
            st <= S_PM;
          end
        end
        S_ZZH: begin
          m_re <= m_nre;
          m_im <= m_nim;
          for (int i = 0; i < NCH; i++) begin
            v_re[i] <= (i < NR) ? W'(1) : '0;
            v_im[i] <= '0;
            u_re[i] <= '0;
            u_im[i] <= '0;
          end
          stage2 <= 1'b1;
          st <= S_PM;
        end
        default: st <= S_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/pim_rx_weights_chk.sv
module pim_rx_weights_chk
  import pim_pkg::*;
#(
  parameter int NR  = 4,
  parameter int W   = 8,
  parameter int SCW = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            done,
  input logic [NR*W-1:0] wgt_re,
  input logic [NR*W-1:0] wgt_im,
  input logic [SCW-1:0]  smp_cnt,
  input pim_state_t      st
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_WGT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(wgt_re) && $stable(wgt_im))); // R7

  AST_BUSY_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (st != S_LOAD) |=> (smp_cnt == '0)); // R8

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (st == S_LOAD)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!done && wgt_re == '0 && wgt_im == '0 && smp_cnt == '0)); // R9

endmodule

bind pim_rx_weights pim_rx_weights_chk #(.NR(NR), .W(W), .SCW(SCW)) u_chk (.*);

// File: tb/sim_pim_rx_weights.sv
module sim_pim_rx_weights;

  localparam int NT = 4, NR = 4, NSC = 52, W = 8, ITER = 5;
  localparam int NCH = NT * NR;
  localparam int NROW = 6;
  // stimulus table: {pattern kind, seed}
  localparam int TAB [NROW][2] = '{'{0, 1}, '{0, 77}, '{1, 3}, '{2, 0}, '{3, 0}, '{4, 0}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst, in_valid;
  logic [W-1:0]    in_re, in_im;
  logic [NR*W-1:0] wgt_re, wgt_im;
  logic            done;
  int n_chk = 0, n_fail = 0;

  pim_rx_weights #(.NT(NT), .NR(NR), .NSC(NSC), .W(W), .ITER(ITER)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .wgt_re(wgt_re), .wgt_im(wgt_im), .done(done));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gen(int kind, int seed, int i, int k, bit imag);
    longint h;
    case (kind)
      0: begin
        h = longint'(seed)*48271 + i*7919 + k*104729 + (imag ? 31337 : 0);
        h = (h*69069 + 12345) % 65536;
        return int'((h >> 4) & 255) - 128;
      end
      1: return (imag ? (((i*3) % 5) - 2) : ((i % 5) - 2)) * ((k % 3 == 0) ? -1 : 1) * 30;
      3: return imag ? -128 : (((i + k) % 2 == 1) ? -128 : 127);
      4: return (i == 5) ? (imag ? -(k % 9)*10 : 40 + (k % 7)*10) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic nrm(inout longint ar[NCH], inout longint ai[NCH]);
    int need = 1, s;
    for (int x = 0; x < 2*NCH; x++) begin
      longint val = (x < NCH) ? ar[x] : ai[x-NCH];
      int b = 1;
      while (!(val >= -(64'sd1 << (b-1)) && val <= (64'sd1 << (b-1)) - 1)) b++;
      if (b > need) need = b;
    end
    s = (need > W) ? need - W : 0;
    for (int x = 0; x < NCH; x++) begin ar[x] = ar[x] >>> s; ai[x] = ai[x] >>> s; end
  endtask

  task automatic model(input int kind, input int seed, output longint er[NR], output longint ej[NR]);
    longint xr[NCH][NSC], xi[NCH][NSC], yr[NCH][NCH], yi[NCH][NCH];
    longint vr[NCH], vi[NCH], ur[NCH], ui[NCH], mr[NR][NR], mi[NR][NR];
    for (int i = 0; i < NCH; i++)
      for (int k = 0; k < NSC; k++) begin xr[i][k] = gen(kind, seed, i, k, 0); xi[i][k] = gen(kind, seed, i, k, 1); end
    for (int i = 0; i < NCH; i++)
      for (int j = 0; j < NCH; j++) begin
        yr[i][j] = 0; yi[i][j] = 0;
        for (int k = 0; k < NSC; k++) begin
          yr[i][j] += xr[i][k]*xr[j][k] + xi[i][k]*xi[j][k];
          yi[i][j] += xi[i][k]*xr[j][k] - xr[i][k]*xi[j][k];
        end
      end
    for (int i = 0; i < NCH; i++) begin vr[i] = 1; vi[i] = 0; end
    for (int it = 0; it < ITER; it++) begin
      for (int i = 0; i < NCH; i++) begin
        ur[i] = 0; ui[i] = 0;
        for (int j = 0; j < NCH; j++) begin
          ur[i] += yr[i][j]*vr[j] - yi[i][j]*vi[j];
          ui[i] += yr[i][j]*vi[j] + yi[i][j]*vr[j];
        end
      end
      nrm(ur, ui); vr = ur; vi = ui;
    end
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++) begin
        mr[a][b] = 0; mi[a][b] = 0;
        for (int c = 0; c < NT; c++) begin
          mr[a][b] += vr[c*NR+a]*vr[c*NR+b] + vi[c*NR+a]*vi[c*NR+b];
          mi[a][b] += vi[c*NR+a]*vr[c*NR+b] - vr[c*NR+a]*vi[c*NR+b];
        end
      end
    for (int i = 0; i < NCH; i++) begin vr[i] = (i < NR) ? 1 : 0; vi[i] = 0; end
    for (int it = 0; it < ITER; it++) begin
      for (int i = 0; i < NCH; i++) begin ur[i] = 0; ui[i] = 0; end
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++) begin
          ur[a] += mr[a][b]*vr[b] - mi[a][b]*vi[b];
          ui[a] += mr[a][b]*vi[b] + mi[a][b]*vr[b];
        end
      nrm(ur, ui); vr = ur; vi = ui;
    end
    for (int r = 0; r < NR; r++) begin er[r] = vr[r]; ej[r] = vi[r]; end
  endtask

  task automatic send(input int kind, input int seed, input int count);
    int n = 0;
    for (int i = 0; i < NCH; i++)
      for (int k = 0; k < NSC; k++)
        if (n < count) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_re = W'(gen(kind, seed, i, k, 0));
          in_im = W'(gen(kind, seed, i, k, 1));
          n++;
        end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // waits for done, offering junk samples while the block is busy (R8)
  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int c = 0; c < 20000 && !got; c++) begin
      @(negedge clk);
      if (done) got = 1'b1;
      else begin in_valid = c[0]; in_re = c[7:0]; in_im = c[10:3]; end
    end
    in_valid = 1'b0;
  endtask

  task automatic run_frame(input int kind, input int seed, input string tag);
    longint er[NR], ej[NR];
    bit got;
    logic [NR*W-1:0] hr, hi;
    model(kind, seed, er, ej);
    send(kind, seed, NCH*NSC);
    wait_done(got);
    check(got, {tag, " R7 done"}, longint'(got), 1);
    for (int r = 0; r < NR; r++) begin
      longint ar = longint'(signed'(wgt_re[r*W +: W]));
      longint ai = longint'(signed'(wgt_im[r*W +: W]));
      check(ar == er[r], {tag, " R6 R4 re"}, ar, er[r]);
      check(ai == ej[r], {tag, " R6 R4 im"}, ai, ej[r]);
    end
    hr = wgt_re; hi = wgt_im;
    @(negedge clk);
    check(!done, {tag, " R7 pulse"}, longint'(done), 0);
    check(wgt_re == hr && wgt_im == hi, {tag, " R7 hold"}, longint'(wgt_re), longint'(hr));
  endtask

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    string tags [5] = '{"R3 random", "R2 rank-one", "R10 zero", "R11 full-scale", "R1 R5 single-channel"};
    rst = 1'b1; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (5) @(negedge clk);
    check(!done && wgt_re == '0 && wgt_im == '0, "R9 reset state", longint'(wgt_re), 0);
    rst = 1'b0;

    // table of patterns; junk is offered while each frame computes (R8)
    for (int t = 0; t < NROW; t++)
      run_frame(TAB[t][0], TAB[t][1], tags[TAB[t][0]]);

    // R9: reset in the middle of a frame discards it and clears the weights
    send(0, 5, 300);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!done && wgt_re == '0 && wgt_im == '0, "R9 mid-frame reset", longint'(wgt_re), 0);
    // R1: counting restarts from sample zero after the reset
    run_frame(0, 9, "R1 R9 after reset");
    // R8: junk offered during the previous frame did not shift this one
    run_frame(1, 11, "R8 back-to-back");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule